// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is a behavioural model of a byte-wide flash memory as seen from its bus. Host writes are not stored directly: they are fed to a command state machine that only acts after a fixed unlock prefix. The recognised commands are byte program, sector erase, chip erase, identifier mode and reset. A correct program or erase sequence launches an internal operation whose length is set by a parameter. While that operation runs, reads return a status byte and writes are ignored. The array is organised as eight equal sectors, and a per-sector protect input keeps program and erase away from the sectors it marks.

Each cycle carries at most one write (`wr_en`) and at most one read (`rd_en`). A read is answered on `rdata` one clock later, and `rdata` keeps its value until the next read. When a read and a write arrive in the same cycle, the read is answered from the mode the block was in before that write. The default configuration is a 2048-byte array, so each sector holds 256 bytes. The two unlock addresses are 0x555 and 0x2AA. The sector number is formed from the three most significant address bits.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array mode, `rdata` is 00h and every byte reads FFh without any command.
- R2: Byte program is four writes: AAh at 0x555, 55h at 0x2AA, A0h at 0x555, then the data at the target address. After BUSY_CYCLES clocks the target byte holds old AND data.
- R3: Programming never sets a bit. If the data asks for a 1 where the byte holds 0, the byte still becomes old AND data, and the block enters a fault mode. In fault mode reads return status with bit 5 set, until an F0h write at any address returns it to array mode.
- R4: While an operation runs, reads return a status byte with bit 7 = complement of programmed data bit 7 (0 for erase), bit 5 = 0 and bits 4:0 = 0. Bit 6 inverts on every status read.
- R5: Every write during a running operation is ignored, including F0h and AAh at 0x555.
- R6: AAh at 0x555, 55h at 0x2AA, then 90h at 0x555 enters identifier mode. Reads then decode the low address byte: 00h returns 01h, 01h returns 20h, and 02h returns 01h or 00h for the protect bit of the addressed sector. Any other offset returns 00h. The mode survives reads and any write other than F0h, and an F0h write leaves it.
- R7: A wrong address or data value in any unlock or command cycle returns the block to array mode, so a later data write changes nothing.
- R8: An F0h write between the cycles of a program or erase sequence returns the block to array mode.
- R9: Sector erase is AAh/0x555, 55h/0x2AA, 80h/0x555, AAh/0x555, 55h/0x2AA, then 30h at any address in the sector. After BUSY_CYCLES clocks every byte of that sector reads FFh, and no other sector changes.
- R10: Chip erase is the same prefix ending with 10h at 0x555. It sets every byte of every unprotected sector to FFh.
- R11: A program or sector erase aimed at a protected sector (`sect_prot` bit = sector number) changes nothing and starts no operation. Chip erase leaves protected sectors intact. The protect bits must be held steady while an operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe for this cycle |
| rd_en | input | 1 | Bus read strobe for this cycle |
| addr | input | ADDR_W | Byte address of the read or write |
| wdata | input | 8 | Write data or command code |
| sect_prot | input | 2**SECT_BITS | Per-sector protect bits |
| rdata | output | 8 | Read result, registered, held between reads |

## Verification
Programming is tried with one byte in each sector, each with a different pattern and both values of bit 7. This separates a correct sector decode and status bit 7 from a fixed answer. A second program then clears further bits, and a third tries to set cleared bits, which tells AND-only programming apart from overwrite and exercises the fault path. Broken sequences use a wrong address, wrong data, a wrong command and an embedded F0h, each followed by a data write that must leave the array alone. Sector erase, chip erase and identifier reads are run with two sectors protected, and a full sweep of the array compared with a bench shadow copy shows both what changed and what stayed the same.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_ARRAY,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_SETUP,
        ST_ERS_SETUP,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_IDENT,
        ST_BUSY,
        ST_FAULT
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_PGM,
        OP_SECT_ERS,
        OP_CHIP_ERS
    } op_kind_e;

endpackage

// File: rtl/fcs_busy_timer.sv
module fcs_busy_timer #(
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             run_q, run_d;

    assign done = run_q && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (start) begin
            cnt_d = CNT_W'(BUSY_CYCLES - 1);
            run_d = 1'b1;
        end else if (done) begin
            run_d = 1'b0;
        end else if (run_q) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
    parameter int ADDR_W    = 11,
    parameter int SECT_BITS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         host_addr,
    output logic [7:0]                host_data,
    input  logic [ADDR_W-1:0]         op_addr,
    output logic [7:0]                op_data,
    input  logic                      pgm_en,
    input  logic [7:0]                pgm_data,
    input  logic                      ers_en,
    input  logic [(1<<SECT_BITS)-1:0] ers_mask
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int OFF_W  = ADDR_W - SECT_BITS;

    logic [7:0] mem_q [DEPTH];

    assign host_data = mem_q[host_addr];
    assign op_data   = mem_q[op_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ers_en && ers_mask[i >> OFF_W]) begin
                    mem_q[i] <= 8'hFF;
                end else if (pgm_en && (op_addr == ADDR_W'(i))) begin
                    mem_q[i] <= pgm_data;
                end
            end
        end
    end
endmodule

// File: rtl/fcs_ident.sv
module fcs_ident #(
    parameter int         ADDR_W    = 11,
    parameter int         SECT_BITS = 3,
    parameter logic [7:0] MFR_CODE  = 8'h01,
    parameter logic [7:0] DEV_CODE  = 8'h20
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [(1<<SECT_BITS)-1:0] sect_prot,
    output logic [7:0]                id_byte
);
    logic [SECT_BITS-1:0] sect;
    assign sect = addr[ADDR_W-1 -: SECT_BITS];

    always_comb begin
        case (addr[7:0])
            8'h00:   id_byte = MFR_CODE;
            8'h01:   id_byte = DEV_CODE;
            8'h02:   id_byte = {7'b0, sect_prot[sect]};
            default: id_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W      = 11,
    parameter int                SECT_BITS   = 3,
    parameter int                BUSY_CYCLES = 8,
    parameter logic [ADDR_W-1:0] UNL_A1      = 'h555,
    parameter logic [ADDR_W-1:0] UNL_A2      = 'h2AA,
    parameter logic [7:0]        UNL_D1      = 8'hAA,
    parameter logic [7:0]        UNL_D2      = 8'h55,
    parameter logic [7:0]        CMD_PGM     = 8'hA0,
    parameter logic [7:0]        CMD_IDENT   = 8'h90,
    parameter logic [7:0]        CMD_ERASE   = 8'h80,
    parameter logic [7:0]        CMD_CHIP    = 8'h10,
    parameter logic [7:0]        CMD_SECT    = 8'h30,
    parameter logic [7:0]        CMD_RST     = 8'hF0,
    localparam int               NUM_SECT    = 1 << SECT_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    input  logic [NUM_SECT-1:0] sect_prot,
    output logic [7:0]          rdata
);
    typedef struct packed {
        seq_state_e        state;
        op_kind_e          op;
        logic [ADDR_W-1:0] op_addr;
        logic [7:0]        op_data;
        logic              toggle;
        logic [7:0]        rdata;
    } seq_regs_t;

    seq_regs_t q, d;

    logic                pgm_en, ers_en, tmr_start, tmr_done, stat7;
    logic [7:0]          pgm_data, host_byte, old_byte, id_byte;
    logic [NUM_SECT-1:0] ers_mask;
    logic [SECT_BITS-1:0] wr_sect, op_sect;

    assign wr_sect = addr[ADDR_W-1 -: SECT_BITS];
    assign op_sect = q.op_addr[ADDR_W-1 -: SECT_BITS];
    assign rdata   = q.rdata;

    fcs_array #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_array (
        .clk(clk), .rst_n(rst_n),
        .host_addr(addr), .host_data(host_byte),
        .op_addr(q.op_addr), .op_data(old_byte),
        .pgm_en(pgm_en), .pgm_data(pgm_data),
        .ers_en(ers_en), .ers_mask(ers_mask)
    );

    fcs_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .done(tmr_done)
    );

    fcs_ident #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_ident (
        .addr(addr), .sect_prot(sect_prot), .id_byte(id_byte)
    );

    always_comb begin
        d         = q;
        pgm_en    = 1'b0;
        pgm_data  = old_byte & q.op_data;
        ers_en    = 1'b0;
        ers_mask  = '0;
        tmr_start = 1'b0;
        stat7     = (q.op == OP_PGM) ? ~q.op_data[7] : 1'b0;

        // read path, answered from the mode held before this cycle's write
        if (rd_en) begin
            case (q.state)
                ST_IDENT: d.rdata = id_byte;
                ST_BUSY: begin
                    d.rdata  = {stat7, q.toggle, 6'b0};
                    d.toggle = ~q.toggle;
                end
                ST_FAULT: begin
                    d.rdata  = {stat7, q.toggle, 1'b1, 5'b0};
                    d.toggle = ~q.toggle;
                end
                default: d.rdata = host_byte;
            endcase
        end

        // command grammar
        if (wr_en) begin
            case (q.state)
                ST_ARRAY: begin
                    if (addr == UNL_A1 && wdata == UNL_D1) d.state = ST_UNL1;
                end
                ST_UNL1: begin
                    d.state = (addr == UNL_A2 && wdata == UNL_D2) ? ST_UNL2 : ST_ARRAY;
                end
                ST_UNL2: begin
                    d.state = ST_ARRAY;
                    if (addr == UNL_A1) begin
                        if (wdata == CMD_PGM)   d.state = ST_PGM_SETUP;
                        if (wdata == CMD_IDENT) d.state = ST_IDENT;
                        if (wdata == CMD_ERASE) d.state = ST_ERS_SETUP;
                    end
                end
                ST_PGM_SETUP: begin
                    d.state = ST_ARRAY;
                    if (!sect_prot[wr_sect]) begin
                        d.state   = ST_BUSY;
                        d.op      = OP_PGM;
                        d.op_addr = addr;
                        d.op_data = wdata;
                        tmr_start = 1'b1;
                    end
                end
                ST_ERS_SETUP: begin
                    d.state = (addr == UNL_A1 && wdata == UNL_D1) ? ST_ERS_UNL1 : ST_ARRAY;
                end
                ST_ERS_UNL1: begin
                    d.state = (addr == UNL_A2 && wdata == UNL_D2) ? ST_ERS_UNL2 : ST_ARRAY;
                end
                ST_ERS_UNL2: begin
                    d.state = ST_ARRAY;
                    if (addr == UNL_A1 && wdata == CMD_CHIP) begin
                        d.state   = ST_BUSY;
                        d.op      = OP_CHIP_ERS;
                        d.op_addr = addr;
                        d.op_data = 8'h00;
                        tmr_start = 1'b1;
                    end else if (wdata == CMD_SECT && !sect_prot[wr_sect]) begin
                        d.state   = ST_BUSY;
                        d.op      = OP_SECT_ERS;
                        d.op_addr = addr;
                        d.op_data = 8'h00;
                        tmr_start = 1'b1;
                    end
                end
                ST_IDENT, ST_FAULT: begin
                    if (wdata == CMD_RST) d.state = ST_ARRAY;
                end
                default: ;
            endcase
        end

        // completion of the running operation
        if (q.state == ST_BUSY && tmr_done) begin
            d.state = ST_ARRAY;
            case (q.op)
                OP_PGM: begin
                    pgm_en = 1'b1;
                    if (|(q.op_data & ~old_byte)) d.state = ST_FAULT;
                end
                OP_SECT_ERS: begin
                    ers_en   = 1'b1;
                    ers_mask = (NUM_SECT'(1) << op_sect) & ~sect_prot;
                end
                default: begin
                    ers_en   = 1'b1;
                    ers_mask = ~sect_prot;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_ARRAY;
            q.op      <= OP_PGM;
            q.op_addr <= '0;
            q.op_data <= '0;
            q.toggle  <= 1'b0;
            q.rdata   <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W    = 11,
    parameter int         SECT_BITS = 3,
    parameter logic [7:0] CMD_RST   = 8'hF0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [7:0]                wdata,
    input seq_state_e                state,
    input logic                      tmr_done,
    input logic                      pgm_en,
    input logic [ADDR_W-1:0]         pgm_addr,
    input logic                      ers_en,
    input logic [(1<<SECT_BITS)-1:0] ers_mask,
    input logic [(1<<SECT_BITS)-1:0] sect_prot
);
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !tmr_done) |=> (state == ST_BUSY)); // R5

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |-> (state == ST_BUSY)); // R4

    AST_PGM_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |-> !sect_prot[pgm_addr[ADDR_W-1 -: SECT_BITS]]); // R11

    AST_ERS_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en |-> ((ers_mask & sect_prot) == '0)); // R11

    AST_IDENT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDENT && !(wr_en && wdata == CMD_RST)) |=> (state == ST_IDENT)); // R6

    AST_FAULT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && !(wr_en && wdata == CMD_RST)) |=> (state == ST_FAULT)); // R3
endmodule

bind flash_cmd_seq fcs_checker #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .CMD_RST(CMD_RST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .state(q.state), .tmr_done(tmr_done),
    .pgm_en(pgm_en), .pgm_addr(q.op_addr),
    .ers_en(ers_en), .ers_mask(ers_mask), .sect_prot(sect_prot)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int BUSY  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    sect_prot = '0;
    logic [7:0]    rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] sh [DEPTH];

    always #4 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .sect_prot(sect_prot), .rdata(rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] dv);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = dv;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic pgm(input logic [AW-1:0] a, input logic [7:0] dv);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, dv);
    endtask

    task automatic ers(input logic [AW-1:0] a, input logic [7:0] cmd);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(a, cmd);
    endtask

    task automatic wait_op();
        repeat (BUSY + 2) @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            rd(AW'(i), v);
            chk(tag, v, sh[i]);
        end
    endtask

    initial begin
        logic [7:0] v, v2, dv;
        logic [AW-1:0] a;
        for (int i = 0; i < DEPTH; i++) sh[i] = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1 rdata at reset", rdata, 8'h00);
        rst_n = 1'b1;
        sweep("R1 erased after reset");

        // R2 and R4: one program per sector, mixed patterns
        for (int s = 0; s < 8; s++) begin
            a  = AW'(s * 256 + s * 17 + 3);
            dv = 8'h5A ^ 8'(s * 8'h13);
            pgm(a, dv);
            rd(a, v);
            chk("R4 program status", v & 8'hBF, {~dv[7], 7'b0});
            rd(a, v2);
            chk("R4 toggle bit", {7'b0, v2[6]}, {7'b0, ~v[6]});
            wait_op();
            sh[a] = dv;
            rd(a, v);
            chk("R2 programmed byte", v, dv);
        end
        sweep("R2 array after programs");

        // R3: AND-only programming and fault path
        a = 11'h003;
        pgm(a, sh[a] & 8'h0F);
        wait_op();
        sh[a] = sh[a] & 8'h0F;
        rd(a, v);
        chk("R3 clear further bits", v, sh[a]);
        pgm(a, 8'hFF);
        wait_op();
        rd(a, v);
        chk("R3 fault status", v & 8'hBF, 8'h20);
        rd(a, v);
        chk("R3 fault persists", v & 8'hBF, 8'h20);
        wr(11'h000, 8'hF0);
        rd(a, v);
        chk("R3 byte kept at 0 bits", v, sh[a]);

        // R5: writes during operation ignored
        a = 11'h010;
        pgm(a, 8'h3C);
        wr(11'h000, 8'hF0);
        wr(11'h555, 8'hAA);
        rd(a, v);
        chk("R5 still busy after writes", v & 8'hBF, 8'h80);
        wait_op();
        sh[a] = 8'h3C;
        rd(a, v);
        chk("R5 program completed", v, 8'h3C);
        pgm(11'h011, 8'h00);
        wait_op();
        sh[11'h011] = 8'h00;
        rd(11'h011, v);
        chk("R5 grammar clean after busy", v, 8'h00);

        // R8: reset between cycles
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h000, 8'hF0);
        wr(11'h555, 8'hA0); wr(11'h020, 8'h00);
        rd(11'h020, v);
        chk("R8 program aborted by F0", v, 8'hFF);

        // R7: wrong address, wrong data, wrong command
        wr(11'h555, 8'hAA); wr(11'h555, 8'h55); wr(11'h555, 8'hA0); wr(11'h021, 8'h00);
        rd(11'h021, v);
        chk("R7 wrong unlock address", v, 8'hFF);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h56); wr(11'h555, 8'hA0); wr(11'h022, 8'h00);
        rd(11'h022, v);
        chk("R7 wrong unlock data", v, 8'hFF);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h77); wr(11'h023, 8'h00);
        rd(11'h023, v);
        chk("R7 unknown command", v, 8'hFF);

        // R6: identifier mode, sectors 1 and 7 protected
        sect_prot = 8'h82;
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h90);
        rd(11'h000, v); chk("R6 maker code", v, 8'h01);
        rd(11'h401, v); chk("R6 device code", v, 8'h20);
        rd(11'h102, v); chk("R6 protected sector", v, 8'h01);
        rd(11'h202, v); chk("R6 open sector", v, 8'h00);
        rd(11'h0A5, v); chk("R6 other offset", v, 8'h00);
        wr(11'h003, 8'h55);
        rd(11'h000, v); chk("R6 survives other write", v, 8'h01);
        wr(11'h000, 8'hF0);
        rd(11'h003, v); chk("R6 F0 returns to array", v, sh[11'h003]);

        // R11: protected targets
        pgm(11'h105, 8'h00);
        rd(11'h105, v);
        chk("R11 program to protected sector", v, 8'hFF);
        ers(11'h7C0, 8'h30);
        rd(11'h7C0 + 11'd29, v);
        chk("R11 erase of protected sector", v, sh[11'h7DD]);

        // R8: reset inside erase sequence
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
        wr(11'h000, 8'hF0);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h200, 8'h30);
        rd(11'h225, v);
        chk("R8 erase aborted by F0", v, sh[11'h225]);

        // R9: sector erase of sector 2
        ers(11'h2F0, 8'h30);
        rd(11'h225, v);
        chk("R4 erase status", v & 8'hBF, 8'h00);
        wait_op();
        for (int i = 0; i < DEPTH; i++) if ((i >> 8) == 2) sh[i] = 8'hFF;
        sweep("R9 sector erase");

        // R10: chip erase with sectors 1 and 7 protected
        sh[11'h7DD] = sh[11'h7DD];
        ers(11'h555, 8'h10);
        wait_op();
        for (int i = 0; i < DEPTH; i++) if (!sect_prot[i >> 8]) sh[i] = 8'hFF;
        sweep("R10 chip erase");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule